// File: doc/BRIEF.md
# UART Receive FIFO Timeout Detector

This block watches one UART receive channel that runs with its receive FIFO enabled. It raises a timeout flag when the FIFO still holds unread characters but nothing new has happened for a set time. Nothing new means that no stop bit has been received and the host has not read the FIFO. The flag goes to the interrupt logic, so the host can collect the last few characters of a burst that did not fill the FIFO to its trigger level.

The timeout length depends on the configured word length P. It is 4·P + 12 bit times. The block counts in ticks of the 16x baud clock, so the terminal count is 16·(4·P + 12) ticks. Receiving the bits and storing them in the FIFO are handled elsewhere. Every pin of this block is a plain control or status signal. It has no data stream, so it needs no valid/ready handshake and has no back-pressure rules.

Top module: `uart_rx_timeout`

## Requirements
- R1: While `fifo_mode` is 0 the counter is held at zero and `timeout_o` is 0one cycle after the first clock edge that sees it.
- R2: While `rx_empty` is 1 the counter is held at zero and `timeout_o` is 0 one cycle after the first clock edge that sees it.
- R3: A one-cycle `stop_mid` pulse clears `timeout_o` and restarts the count from zero.
- R4: `timeout_o` rises on the clock edge that counts the 16·(4·P+12)-th tick since the last restart. The `wlen_sel` encoding is 0→P=5 (512 ticks), 1→P=6 (576 ticks), 2→P=7 (640 ticks) and 3→P=8 (704 ticks).
- R5: Only cycles with `tick16` high advance the count. Cycles without a tick leave the count unchanged.
- R6: A `host_rd` pulse clears `timeout_o` and restarts the count from zero.
- R7: Once set, `timeout_o` stays high until a restart event or a reset, however many more ticks arrive.
- R8: A change of `wlen_sel` or of `fifo_mode` between two clock edges clears `timeout_o` and restarts the count.
- R9: Synchronous `rst` clears the count and `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| wlen_sel | input | 2 | Word length select: 0..3 selects 5..8 bits |
| fifo_mode | input | 1 | 1 when the receive FIFO is enabled |
| rx_empty | input | 1 | 1 when the receive FIFO holds no data |
| stop_mid | input | 1 | Pulse at the centre of each received stop bit |
| host_rd | input | 1 | Pulse on each host read of the receive FIFO |
| timeout_o | output | 1 | Sticky receive timeout flag |

## Verification
The case hardest to reach is an exact terminal count. A timeout needs 512 to 704 ticks with no stop bit, no read, no empty FIFO and no configuration change. Random stimulus almost always breaks such a window before it ends. Directed runs therefore hold every restart source quiet and stop one tick short of the terminal count, then apply the final tick, for each word length and with ticks spaced out by idle cycles. A long random phase with rare restart events is then compared cycle by cycle against a bench model.

// File: rtl/uto_pkg.sv
package uto_pkg;

  // Sources that restart the idle count
  typedef struct packed {
    logic stop_seen;
    logic host_read;
    logic fifo_empty;
    logic mode_off;
    logic cfg_change;
  } uto_restart_t;

  // Terminal count in 16x ticks for one word length
  function automatic int ticks_for_wlen(int tpb, int mul, int extra, int wlen);
    return tpb * (mul * wlen + extra);
  endfunction

endpackage

// File: rtl/uto_limit_calc.sv
module uto_limit_calc #(
  parameter int SEL_W         = 2,
  parameter int MIN_WLEN      = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int WLEN_MUL      = 4,
  parameter int EXTRA_BITS    = 12,
  parameter int CNT_W         = 10
) (
  input  logic [SEL_W-1:0] wlen_sel,
  output logic [CNT_W-1:0] limit
);
  import uto_pkg::*;

  localparam int N_SEL = 2 ** SEL_W;

  logic [CNT_W-1:0] lut [N_SEL];

  for (genvar i = 0; i < N_SEL; i++) begin : g_lut
    assign lut[i] = CNT_W'(ticks_for_wlen(TICKS_PER_BIT, WLEN_MUL, EXTRA_BITS, MIN_WLEN + i));
  end

  assign limit = lut[wlen_sel];

endmodule

// File: rtl/uto_cfg_watch.sv
module uto_cfg_watch #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] wlen_sel,
  input  logic             fifo_mode,
  output logic             cfg_change
);
  logic [SEL_W-1:0] sel_q;
  logic             mode_q;

  always_ff @(posedge clk) begin
    sel_q  <= wlen_sel;
    mode_q <= fifo_mode;
  end

  assign cfg_change = !rst && ((wlen_sel != sel_q) || (fifo_mode != mode_q));

endmodule

// File: rtl/uto_tick_counter.sv
module uto_tick_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             flag
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (tick && !flag) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == limit) flag <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int SEL_W         = 2,
  parameter int MIN_WLEN      = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int WLEN_MUL      = 4,
  parameter int EXTRA_BITS    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic [SEL_W-1:0] wlen_sel,
  input  logic             fifo_mode,
  input  logic             rx_empty,
  input  logic             stop_mid,
  input  logic             host_rd,
  output logic             timeout_o
);
  import uto_pkg::*;

  localparam int MAX_LIMIT = ticks_for_wlen(TICKS_PER_BIT, WLEN_MUL, EXTRA_BITS,
                                            MIN_WLEN + (2 ** SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic             cfg_change;
  logic [CNT_W-1:0] limit;
  uto_restart_t     rs;
  logic             restart;

  uto_cfg_watch #(.SEL_W(SEL_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wlen_sel   (wlen_sel),
    .fifo_mode  (fifo_mode),
    .cfg_change (cfg_change)
  );

  uto_limit_calc #(
    .SEL_W         (SEL_W),
    .MIN_WLEN      (MIN_WLEN),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .WLEN_MUL      (WLEN_MUL),
    .EXTRA_BITS    (EXTRA_BITS),
    .CNT_W         (CNT_W)
  ) u_lim (
    .wlen_sel (wlen_sel),
    .limit    (limit)
  );

  always_comb begin
    rs.stop_seen  = stop_mid;
    rs.host_read  = host_rd;
    rs.fifo_empty = rx_empty;
    rs.mode_off   = !fifo_mode;
    rs.cfg_change = cfg_change;
  end

  assign restart = |rs;

  uto_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .restart (restart),
    .limit   (limit),
    .flag    (timeout_o)
  );

endmodule

// File: rtl/uart_rx_timeout_chk.sv
module uart_rx_timeout_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tick16,
  input logic [SEL_W-1:0] wlen_sel,
  input logic             fifo_mode,
  input logic             rx_empty,
  input logic             stop_mid,
  input logic             host_rd,
  input logic             timeout_o
);
  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> !timeout_o); // R1
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !timeout_o); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_mid |=> !timeout_o); // R3
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> $past(tick16)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> !timeout_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !stop_mid && !host_rd && !rx_empty && fifo_mode
     && $stable(wlen_sel) && $stable(fifo_mode)) |=> timeout_o); // R7
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$stable(wlen_sel) |=> !timeout_o); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !timeout_o); // R9
endmodule

bind uart_rx_timeout uart_rx_timeout_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick16    (tick16),
  .wlen_sel  (wlen_sel),
  .fifo_mode (fifo_mode),
  .rx_empty  (rx_empty),
  .stop_mid  (stop_mid),
  .host_rd   (host_rd),
  .timeout_o (timeout_o)
);

// File: tb/uart_rx_timeout_tb.sv
`timescale 1ns/1ps
module uart_rx_timeout_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] wlen_sel = 2'd2;
  logic       fifo_mode = 1'b1;
  logic       rx_empty = 1'b0;
  logic       stop_mid = 1'b0;
  logic       host_rd = 1'b0;
  logic       timeout_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  int         m_cnt = 0;
  bit         m_flag = 0;
  logic [1:0] m_sel = 2'd2;
  logic       m_mode = 1'b1;

  always #2 clk = ~clk;

  uart_rx_timeout u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .wlen_sel(wlen_sel),
    .fifo_mode(fifo_mode), .rx_empty(rx_empty), .stop_mid(stop_mid),
    .host_rd(host_rd), .timeout_o(timeout_o)
  );

  function automatic int limit_of(logic [1:0] s);
    return 16 * (4 * (5 + int'(s)) + 12);
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: timeout_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit rs;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_sel = wlen_sel; m_mode = fifo_mode;
    end else begin
      rs = stop_mid || host_rd || rx_empty || !fifo_mode
           || (wlen_sel != m_sel) || (fifo_mode != m_mode);
      m_sel = wlen_sel; m_mode = fifo_mode;
      if (rs) begin
        m_cnt = 0; m_flag = 0;
      end else if (tick16 && !m_flag) begin
        m_cnt++;
        if (m_cnt == limit_of(wlen_sel)) m_flag = 1;
      end
    end
  endtask

  task automatic step(string req = "R4 model");
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, timeout_o, m_flag);
  endtask

  task automatic run_ticks(int n);
    tick16 = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick16 = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_mid = 1'b1; step("R3 model"); stop_mid = 1'b0;
  endtask

  initial begin
    #(4.0 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R9 model"); step("R9 model");
    check("R9 reset state", timeout_o, 1'b0);
    rst = 1'b0;
    step();
    pulse_stop();

    // R4: 7-bit word boundary
    run_ticks(639);
    check("R4 one short of 640", timeout_o, 1'b0);
    run_ticks(1);
    check("R4 at 640", timeout_o, 1'b1);
    // R7: sticky
    run_ticks(50);
    repeat (10) step();
    check("R7 sticky", timeout_o, 1'b1);
    // R6: read clears
    host_rd = 1'b1; step("R6 model"); host_rd = 1'b0;
    check("R6 read clears", timeout_o, 1'b0);
    // R5: spaced ticks
    for (int i = 0; i < 639; i++) begin
      tick16 = 1'b1; step(); tick16 = 1'b0; step();
    end
    check("R5 spaced 639", timeout_o, 1'b0);
    run_ticks(1);
    check("R5 spaced 640", timeout_o, 1'b1);
    // R3: stop restart
    pulse_stop();
    check("R3 stop clears", timeout_o, 1'b0);
    run_ticks(600); pulse_stop(); run_ticks(100);
    check("R3 restarted count", timeout_o, 1'b0);
    run_ticks(540);
    check("R3 full after restart", timeout_o, 1'b1);
    // R2: empty FIFO
    rx_empty = 1'b1; run_ticks(800);
    check("R2 empty no flag", timeout_o, 1'b0);
    rx_empty = 1'b0; step();
    // R1: mode off
    fifo_mode = 1'b0; run_ticks(800);
    check("R1 mode off no flag", timeout_o, 1'b0);
    fifo_mode = 1'b1; step();
    run_ticks(640);
    check("R1 back on counts", timeout_o, 1'b1);
    // R8: config change
    wlen_sel = 2'd3; step("R8 model");
    check("R8 sel change clears", timeout_o, 1'b0);
    run_ticks(703);
    check("R4 8-bit one short", timeout_o, 1'b0);
    run_ticks(1);
    check("R4 8-bit at 704", timeout_o, 1'b1);
    wlen_sel = 2'd0; step();
    run_ticks(511);
    check("R4 5-bit one short", timeout_o, 1'b0);
    run_ticks(1);
    check("R4 5-bit at 512", timeout_o, 1'b1);
    fifo_mode = 1'b0; step(); fifo_mode = 1'b1; step("R8 model");
    check("R8 mode toggle clears", timeout_o, 1'b0);
    wlen_sel = 2'd1; step(); run_ticks(576);
    check("R4 6-bit at 576", timeout_o, 1'b1);
    // R9: reset mid-flag
    rst = 1'b1; step("R9 model");
    check("R9 reset clears", timeout_o, 1'b0);
    rst = 1'b0; step();

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 40000; i++) begin
      tick16   = ($urandom_range(0, 2) != 0);
      stop_mid = ($urandom_range(0, 2999) == 0);
      host_rd  = ($urandom_range(0, 3999) == 0);
      if ($urandom_range(0, 2999) == 0) rx_empty = ~rx_empty;
      if ($urandom_range(0, 4999) == 0) wlen_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5999) == 0) fifo_mode = ~fifo_mode;
      rst = ($urandom_range(0, 9999) == 0);
      step("R4 random model");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule